// File: doc/BRIEF.md
# ECC Codeword Tag Matcher with Butterfly Weight Counting

The block decides how far an incoming tag lies from a stored codeword that was written in systematic form. The low `TAG_W` bits of the stored word hold the tag itself, and the upper `PAR_W` bits hold check bits from a generator matrix. The data field is compared with the incoming tag straight away. In parallel, a combinational encoder derives check bits from the incoming tag, and only the check-bit comparison waits for that encoder.

The difference bits are counted by trees of half adders wired as a butterfly. Each output bit of such a tree stands for a power-of-two count of ones. A second level handles the result. It ORs together every weighted bit above the detection limit. It feeds the remaining bits, grouped by weight, into further butterfly trees. It then classes the Hamming distance as exact, correctable, detectable-only or out of range. The class is registered and presented as four flags one cycle after the inputs. A cache lookup uses these flags to tell a hit, a hit needing a single-bit repair, a reportable fault, or a miss.

Top module: `tag_ecc_matcher`

## Requirements
- R1: While `rst_n` is sampled low at a rising edge, all four flags read 0 after that edge.
- R2: The flags after a rising edge describe the `tag_i` and `stored_cw_i` values sampled at that edge; new inputs do not change the flags before the next edge.
- R3: The stored word is laid out with the tag copy in `stored_cw_i[15:0]` and the check bits in `stored_cw_i[21:16]`. The check bit j equals the XOR of every tag bit i whose column code has bit j set. The column code of tag bit i is the i-th smallest 6-bit value with exactly three ones (7, 11, 13, 14, 19, ...).
- R4: Out of reset, exactly one of the four flags is high in every cycle.
- R5: `match_o` is high only when the Hamming distance between the encoded tag and the stored word is 0.
- R6: `corr_o` is high when the distance is 1 (the correction limit).
- R7: `fault_o` is high when the distance is 2 (above the correction limit, within the detection limit).
- R8: `miss_o` is high for any distance of 3 or more, up to every bit differing.
- R9: Differences in the check-bit field count toward the distance exactly as differences in the data field do.
- R10: When the data field alone differs from the tag in more than 2 bits, `miss_o` is high whatever the check-bit field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tag_i | input | TAG_W (16) | Incoming tag |
| stored_cw_i | input | TAG_W+PAR_W (22) | Stored systematic codeword, check bits on top |
| match_o | output | 1 | Distance is zero |
| corr_o | output | 1 | Distance within the correction limit |
| fault_o | output | 1 | Distance detectable but not correctable |
| miss_o | output | 1 | Distance beyond the detection limit |

## Verification
The bench aims at the class boundaries. It injects exactly 0, 1, 2, 3 and 4 distinct bit flips into the data field only, then into the check field only, then anywhere in the word. If a butterfly stage lost a carry, a flip pair would read as one flip and show as correctable instead of a fault. If a weight were mis-assigned, a single flip in the check field would be misclassed. Exact-match cases with varied tags catch an encoder column that is wrong: a correct word would then show as correctable. Fully inverted words and data fields that are far off with garbage check bits exercise saturation, where a second level that wraps instead of saturating would report a match or a fault. A latency case samples just before the edge to catch an output that is not registered.

// File: rtl/tmatch_pkg.sv
// Package: shared types and elaboration-time helpers for the tag matcher.
// Assumes: weights of butterfly outputs are powers of two given by the
// popcount of the output index inside its own tree.
package tmatch_pkg;

    typedef enum logic [1:0] {
        CLS_MATCH = 2'd0,
        CLS_CORR  = 2'd1,
        CLS_FAULT = 2'd2,
        CLS_MISS  = 2'd3
    } dist_cls_e;

    // Number of butterfly stages needed for n inputs (at least one).
    function automatic int bwa_stages(int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

    // Weight exponent of position pos in a flat vector made of a tree of
    // np_lo outputs followed by a second tree.
    function automatic int bwa_exp(int pos, int np_lo);
        int loc;
        loc = (pos < np_lo) ? pos : pos - np_lo;
        return $countones(loc);
    endfunction

endpackage

// File: rtl/tm_parity_enc.sv
// Module: combinational check-bit generator driven by a generator matrix.
// Assumes: row j of GEN masks the tag bits that feed check bit j.
module tm_parity_enc #(
    parameter int TAG_W = 16,
    parameter int PAR_W = 6,
    parameter logic [PAR_W-1:0][TAG_W-1:0] GEN = '0
) (
    input  logic [TAG_W-1:0] tag_i,
    output logic [PAR_W-1:0] par_o
);

    // Each check bit is the XOR of the tag bits selected by its row.
    always_comb begin
        for (int j = 0; j < PAR_W; j++) begin
            par_o[j] = ^(tag_i & GEN[j]);
        end
    end

endmodule

// File: rtl/tm_bwa.sv
// Module: butterfly weight accumulator built only from half adders.
// Stage s pairs indices that differ in bit s: the sum stays at the lower
// index, the carry moves to the upper one. Output j carries the weight
// 2**popcount(j), and the weighted sum of outputs equals the input count.
// Assumes: unused inputs beyond N_IN are tied to zero.
module tm_bwa #(
    parameter int N_IN = 16,
    localparam int STG = tmatch_pkg::bwa_stages(N_IN),
    localparam int N_P = 1 << STG
) (
    input  logic [N_IN-1:0] bits_i,
    output logic [N_P-1:0]  wbits_o
);

    logic [STG:0][N_P-1:0] lvl;

    // Stage 0: raw difference bits, padded to a power of two.
    generate
        if (N_P == N_IN) begin : g_nopad
            assign lvl[0] = bits_i;
        end else begin : g_pad
            assign lvl[0] = {{(N_P - N_IN){1'b0}}, bits_i};
        end
    endgenerate

    // Butterfly stages of half adders.
    genvar s, j;
    generate
        for (s = 0; s < STG; s++) begin : g_stage
            for (j = 0; j < N_P; j++) begin : g_pos
                if (((j >> s) & 1) == 0) begin : g_ha
                    assign lvl[s+1][j]            = lvl[s][j] ^ lvl[s][j | (1 << s)];
                    assign lvl[s+1][j | (1 << s)] = lvl[s][j] & lvl[s][j | (1 << s)];
                end
            end
        end
    endgenerate

    assign wbits_o = lvl[STG];

endmodule

// File: rtl/tm_range_class.sv
// Module: second level. Weighted first-level bits above RMAX are ORed into
// an over-range term; bits of each lower power-of-two weight go to their
// own butterfly tree, whose outputs are folded into a saturated distance.
// Assumes: the input is two first-level trees of NP_D and NP_P outputs.
module tm_range_class
    import tmatch_pkg::*;
#(
    parameter int NP_D = 16,
    parameter int NP_P = 8,
    parameter int TMAX = 1,
    parameter int RMAX = 2
) (
    input  logic [NP_D+NP_P-1:0] wbits_i,
    output dist_cls_e            cls_o
);

    localparam int FL_W = NP_D + NP_P;
    localparam int NCLS = $clog2(RMAX + 1);
    localparam int NP2  = 1 << bwa_stages(FL_W);
    localparam int SAT  = RMAX + 1;

    logic [NCLS-1:0][FL_W-1:0] cls_vec;
    logic [NCLS-1:0][NP2-1:0]  l2;
    logic                      over_l1;
    logic                      over_all;
    int                        acc;

    // Route each first-level bit to the tree of its weight class.
    genvar c, p;
    generate
        for (c = 0; c < NCLS; c++) begin : g_cls
            for (p = 0; p < FL_W; p++) begin : g_sel
                if (bwa_exp(p, NP_D) == c) begin : g_on
                    assign cls_vec[c][p] = wbits_i[p];
                end else begin : g_off
                    assign cls_vec[c][p] = 1'b0;
                end
            end
            tm_bwa #(.N_IN(FL_W)) u_l2 (
                .bits_i  (cls_vec[c]),
                .wbits_o (l2[c])
            );
        end
    endgenerate

    // OR of all first-level bits whose weight exceeds the detection limit.
    always_comb begin
        over_l1 = 1'b0;
        for (int q = 0; q < FL_W; q++) begin
            if ((1 << bwa_exp(q, NP_D)) > RMAX) over_l1 = over_l1 | wbits_i[q];
        end
    end

    // Fold second-level outputs into a distance saturated at RMAX+1.
    always_comb begin
        over_all = over_l1;
        acc      = 0;
        for (int k = 0; k < NCLS; k++) begin
            for (int m = 0; m < NP2; m++) begin
                if (l2[k][m]) begin
                    if ((1 << (k + $countones(m))) > RMAX) begin
                        over_all = 1'b1;
                    end else begin
                        acc = acc + (1 << (k + $countones(m)));
                        if (acc > SAT) acc = SAT;
                    end
                end
            end
        end
    end

    // Map the saturated distance to its class.
    always_comb begin
        if (over_all || acc > RMAX) cls_o = CLS_MISS;
        else if (acc == 0)          cls_o = CLS_MATCH;
        else if (acc <= TMAX)       cls_o = CLS_CORR;
        else                        cls_o = CLS_FAULT;
    end

endmodule

// File: rtl/tag_ecc_matcher.sv
// Module: top of the tag matcher. The data field is XORed with the tag at
// once while the encoder builds check bits; two first-level butterfly
// trees count both difference vectors, the second level classes the
// distance, and the class is registered as four one-hot flags.
// Assumes: stored_cw_i holds {check bits, tag copy}; synchronous reset.
module tag_ecc_matcher
    import tmatch_pkg::*;
#(
    parameter int TAG_W = 16,
    parameter int PAR_W = 6,
    parameter int TMAX  = 1,
    parameter int RMAX  = 2,
    parameter logic [PAR_W-1:0][TAG_W-1:0] GEN =
        96'hFC00_03F0_E38E_9A6D_555B_2CB7
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [TAG_W-1:0]         tag_i,
    input  logic [TAG_W+PAR_W-1:0]   stored_cw_i,
    output logic                     match_o,
    output logic                     corr_o,
    output logic                     fault_o,
    output logic                     miss_o
);

    localparam int CW_W = TAG_W + PAR_W;
    localparam int NP_D = 1 << bwa_stages(TAG_W);
    localparam int NP_P = 1 << bwa_stages(PAR_W);

    logic [TAG_W-1:0] data_diff;
    logic [PAR_W-1:0] enc_par;
    logic [PAR_W-1:0] par_diff;
    logic [NP_D-1:0]  w_data;
    logic [NP_P-1:0]  w_par;
    dist_cls_e        cls;
    logic [3:0]       flags_q;

    // Data-field difference needs no encoding.
    assign data_diff = tag_i ^ stored_cw_i[TAG_W-1:0];

    tm_parity_enc #(.TAG_W(TAG_W), .PAR_W(PAR_W), .GEN(GEN)) u_enc (
        .tag_i (tag_i),
        .par_o (enc_par)
    );

    // Check-field difference waits for the encoder.
    assign par_diff = enc_par ^ stored_cw_i[CW_W-1:TAG_W];

    tm_bwa #(.N_IN(TAG_W)) u_bwa_data (
        .bits_i  (data_diff),
        .wbits_o (w_data)
    );

    tm_bwa #(.N_IN(PAR_W)) u_bwa_par (
        .bits_i  (par_diff),
        .wbits_o (w_par)
    );

    tm_range_class #(.NP_D(NP_D), .NP_P(NP_P), .TMAX(TMAX), .RMAX(RMAX)) u_cls (
        .wbits_i ({w_par, w_data}),
        .cls_o   (cls)
    );

    // Register the class as one-hot flags; cleared in reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= 4'b0000;
        end else begin
            unique case (cls)
                CLS_MATCH: flags_q <= 4'b1000;
                CLS_CORR:  flags_q <= 4'b0100;
                CLS_FAULT: flags_q <= 4'b0010;
                default:   flags_q <= 4'b0001;
            endcase
        end
    end

    assign {match_o, corr_o, fault_o, miss_o} = flags_q;

endmodule

// File: rtl/tmatch_checker.sv
// Module: assertion checker attached to the top by bind.
// Assumes: data field is the low TAG_W bits of the stored word.
module tmatch_checker #(
    parameter int TAG_W = 16,
    parameter int CW_W  = 22,
    parameter int RMAX  = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TAG_W-1:0]  tag_i,
    input logic [CW_W-1:0]   stored_cw_i,
    input logic              match_o,
    input logic              corr_o,
    input logic              fault_o,
    input logic              miss_o
);

    logic was_in_reset = 1'b0;

    // Track reset at the previous edge and check the cleared flags.
    always_ff @(posedge clk) begin
        was_in_reset <= !rst_n;
        if (was_in_reset) begin
            a_r1_reset_clear: assert ({match_o, corr_o, fault_o, miss_o} == 4'b0000)
                else $error("R1: flags not cleared by reset");
        end
    end

    a_r4_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ($countones({match_o, corr_o, fault_o, miss_o}) == 1))
        else $error("R4: flags not one-hot");

    a_r10_data_far_miss: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(tag_i ^ stored_cw_i[TAG_W-1:0]) > RMAX) |=> miss_o)
        else $error("R10: far data field not a miss");

    a_r5_data_diff_no_match: assert property (@(posedge clk) disable iff (!rst_n)
        (tag_i != stored_cw_i[TAG_W-1:0]) |=> !match_o)
        else $error("R5: match with differing data field");

    a_r2_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $stable(tag_i) && $stable(stored_cw_i))
            |=> $stable({match_o, corr_o, fault_o, miss_o}))
        else $error("R2: flags moved with stable inputs");

endmodule

bind tag_ecc_matcher tmatch_checker #(
    .TAG_W (TAG_W),
    .CW_W  (TAG_W + PAR_W),
    .RMAX  (RMAX)
) u_tmatch_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .tag_i       (tag_i),
    .stored_cw_i (stored_cw_i),
    .match_o     (match_o),
    .corr_o      (corr_o),
    .fault_o     (fault_o),
    .miss_o      (miss_o)
);

// File: tb/tb_tag_ecc_matcher.sv
// Directed bench for the tag matcher; one task per scenario.
module tb_tag_ecc_matcher;

    localparam int CLK_PERIOD = 10;
    localparam int TW = 16;
    localparam int PW = 6;
    localparam int CW = TW + PW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [TW-1:0] tag = '0;
    logic [CW-1:0] stored = '0;
    logic          match_o, corr_o, fault_o, miss_o;
    int            n_chk = 0;
    int            n_fail = 0;
    bit            done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tag_ecc_matcher dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .tag_i       (tag),
        .stored_cw_i (stored),
        .match_o     (match_o),
        .corr_o      (corr_o),
        .fault_o     (fault_o),
        .miss_o      (miss_o)
    );

    // Check bits per R3: column code i is the i-th 6-bit value with three ones.
    function automatic logic [PW-1:0] ref_par(logic [TW-1:0] t);
        logic [PW-1:0] r = '0;
        int i = 0;
        for (int v = 0; v < (1 << PW); v++) begin
            if ($countones(v) == 3 && i < TW) begin
                for (int j = 0; j < PW; j++) r[j] = r[j] ^ (t[i] & v[j]);
                i++;
            end
        end
        return r;
    endfunction

    function automatic logic [3:0] exp_flags(int d);
        if (d == 0) return 4'b1000;
        if (d == 1) return 4'b0100;
        if (d == 2) return 4'b0010;
        return 4'b0001;
    endfunction

    // Mask with n distinct set bits inside positions lo..hi.
    function automatic logic [CW-1:0] flip_mask(int n, int lo, int hi);
        logic [CW-1:0] m = '0;
        int k = 0;
        while (k < n) begin
            int pos = lo + int'($urandom % (hi - lo + 1));
            if (!m[pos]) begin
                m[pos] = 1'b1;
                k++;
            end
        end
        return m;
    endfunction

    task automatic check(string req, logic [3:0] expv);
        logic [3:0] got = {match_o, corr_o, fault_o, miss_o};
        n_chk++;
        if (got !== expv) begin
            n_fail++;
            $display("FAIL %s: flags got %b expected %b", req, got, expv);
        end
    endtask

    task automatic apply(logic [TW-1:0] t, logic [CW-1:0] cw);
        @(negedge clk);
        tag = t;
        stored = cw;
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic t_reset();
        tag = 16'h1234;
        stored = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R1 reset clears flags", 4'b0000);
        rst_n = 1'b1;
    endtask

    task automatic t_exact();
        logic [TW-1:0] tags [5] = '{16'h0000, 16'hFFFF, 16'hA5A5, 16'h0001, 16'h8000};
        foreach (tags[i]) begin
            apply(tags[i], {ref_par(tags[i]), tags[i]});
            check("R3 R5 exact codeword matches", 4'b1000);
        end
        for (int r = 0; r < 4; r++) begin
            logic [TW-1:0] t = TW'($urandom);
            apply(t, {ref_par(t), t});
            check("R3 R5 random exact codeword", 4'b1000);
        end
    endtask

    task automatic t_flips(string req, int lo, int hi, int reps);
        for (int n = 0; n <= 4; n++) begin
            for (int r = 0; r < reps; r++) begin
                logic [TW-1:0] t = TW'($urandom);
                apply(t, {ref_par(t), t} ^ flip_mask(n, lo, hi));
                check(n == 1 ? {req, " R6"} : n == 2 ? {req, " R7"} :
                      n >= 3 ? {req, " R8"} : {req, " R5"}, exp_flags(n));
            end
        end
    endtask

    task automatic t_inverted();
        for (int r = 0; r < 3; r++) begin
            logic [TW-1:0] t = TW'($urandom);
            apply(t, ~{ref_par(t), t});
            check("R8 fully inverted word is a miss", 4'b0001);
        end
    endtask

    task automatic t_data_far();
        for (int r = 0; r < 4; r++) begin
            logic [TW-1:0] t = TW'($urandom);
            logic [CW-1:0] cw = {PW'($urandom), t} ^ flip_mask(3 + r % 2, 0, TW - 1);
            apply(t, cw);
            check("R10 far data field with any check bits", 4'b0001);
        end
    endtask

    task automatic t_latency();
        logic [TW-1:0] t = 16'h3C5A;
        apply(t, {ref_par(t), t});
        @(negedge clk);
        stored = {ref_par(t), t} ^ flip_mask(2, 0, CW - 1);
        #(CLK_PERIOD/4);
        check("R2 flags hold until next edge", 4'b1000);
        @(posedge clk);
        @(negedge clk);
        check("R2 flags follow sampled inputs", 4'b0010);
    endtask

    task automatic t_onehot();
        for (int r = 0; r < 10; r++) begin
            logic [TW-1:0] t = TW'($urandom);
            apply(t, {ref_par(t), t} ^ flip_mask(r % 6, 0, CW - 1));
            n_chk++;
            if ($countones({match_o, corr_o, fault_o, miss_o}) != 1) begin
                n_fail++;
                $display("FAIL R4: flags got %b expected one-hot",
                         {match_o, corr_o, fault_o, miss_o});
            end
        end
    endtask

    task automatic t_mid_reset();
        logic [TW-1:0] t = 16'h0F0F;
        apply(t, {ref_par(t), t} ^ 22'h3);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R1 reset during operation clears flags", 4'b0000);
        rst_n = 1'b1;
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    endtask

    initial begin
        t_reset();
        t_exact();
        t_flips("data field", 0, TW - 1, 3);
        t_flips("R9 check field", TW, CW - 1, 3);
        t_flips("whole word", 0, CW - 1, 3);
        t_inverted();
        t_data_far();
        t_latency();
        t_onehot();
        t_mid_reset();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 20000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

endmodule